// File: doc/BRIEF.md
# Three-Channel Audio Interval Timer Unit

This block gives a sound-processor subsystem three interval timers behind a byte-wide register bus. A single-cycle base strobe, arriving at the fast timer rate, drives one timer directly. The other two timers run from a divided strobe that fires on every eighth base strobe. Each enabled timer counts strobes in an internal divider until it reaches its programmed period. It then restarts the divider and advances a small output counter. Software reads that counter to learn how many periods have passed. The read also clears the counter.

The control register holds one enable bit per timer and a boot-ROM enable bit, which drives an output pin. The control register, the test register and the period registers can be written but always read back as zero. Only the output counters return data. A hard reset (asynchronous, active low) loads the output counters with all ones. A synchronous soft-reset strobe loads them with zero. Both resets restore the control and test registers to their reset values and clear the dividers and the prescaler.

Top module: `atu_timer_unit`

## Requirements
- R1: After hard reset, `rom_enable` is 1, every timer is disabled, every period register is 0, and each output counter (read address 5+i) holds 0x0F.
- R2: A one-cycle `soft_rst` sets the control register to 0xB0 and the test register to 0x0A. It sets every output counter, every divider and the prescaler to 0, and leaves the period registers as they were.
- R3: A read at address 0 (test), 1 (control) or 2..4 (period of timer 0..2) returns 0x00, whatever was written there.
- R4: Timer i counts only while bit i of the control register (address 1) is 1. A disabled timer holds its output counter.
- R5: A timer's period is its 8-bit period register value, and a value of 0 gives a period of 256 strobes.
- R6: Timer 2 advances its divider on every base strobe. Timers 0 and 1 advance theirs on every eighth base strobe, counted from reset.
- R7: When the divider reaches the period, it returns to 0 and the 4-bit output counter increments, wrapping from 15 to 0.
- R8: A read at address 5+i returns timer i's output counter in the low 4 bits and clears the counter in that same access.
- R9: A control write that takes bit i from 0 to 1 clears timer i's divider and output counter. Rewriting a bit that is already 1 changes nothing.
- R10: `rom_enable` equals bit 7 of the last value written to the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft-reset strobe |
| base_tick | input | 1 | Single-cycle base timing strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| rom_enable | output | 1 | Boot-ROM enable, control bit 7 |

## Verification
The bench builds the unit with its default parameters: three timers, 8-bit periods, 4-bit counters and a divide-by-8 slow path. These values make the 256-strobe period for a zero target reachable in a few hundred cycles. They also let the bench count the wrap of a 4-bit counter and compare the two strobe rates directly. It works out the divider phase from the number of strobes it has issued since each reset. This lets it show that a rising enable clears the divider as well as the counter.

// File: rtl/atu_pkg.sv
package atu_pkg;
   // register class selected by the bus address
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_TEST,
      SEL_CTRL,
      SEL_TGT,
      SEL_CNT
   } atu_sel_e;

   localparam int unsigned ATU_BUS_W = 8;
endpackage

// File: rtl/atu_prescale.sv
module atu_prescale #(
   parameter int unsigned RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic base_tick,
   output logic slow_tick
);
   localparam int unsigned PW = (RATIO > 2) ? $clog2(RATIO) : 1;
   localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

   generate
      if (RATIO < 2) begin : g_bad_ratio
         $error("atu_prescale: RATIO must be at least 2");
      end
   endgenerate

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (clr)
         phase_q <= '0;
      else if (base_tick)
         phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
   end

   assign slow_tick = base_tick && (phase_q == LAST);
endmodule

// File: rtl/atu_channel.sv
module atu_channel #(
   parameter int unsigned TGT_W = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             tick,
   input  logic             enable,
   input  logic             start,
   input  logic [TGT_W-1:0] target,
   input  logic             rd_clr,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] HARD_CNT = '1;
   localparam logic [TGT_W:0]   FULL_PER = {1'b1, {TGT_W{1'b0}}};

   logic [TGT_W-1:0] div_q;
   logic [TGT_W:0]   period;
   logic [TGT_W:0]   div_inc;
   logic             step;
   logic             wrap;

   assign period  = (target == '0) ? FULL_PER : {1'b0, target};
   assign div_inc = {1'b0, div_q} + 1'b1;
   assign step    = tick && enable;
   assign wrap    = step && (div_inc == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         count <= HARD_CNT;
      end else if (soft_clr || start) begin
         div_q <= '0;
         count <= '0;
      end else begin
         if (step)
            div_q <= wrap ? '0 : div_inc[TGT_W-1:0];
         count <= (rd_clr ? '0 : count) + CNT_W'(wrap);
      end
   end
endmodule

// File: rtl/atu_timer_unit.sv
module atu_timer_unit
   import atu_pkg::*;
#(
   parameter int unsigned N_TMR      = 3,
   parameter int unsigned TGT_W      = 8,
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned SLOW_RATIO = 8,
   parameter int unsigned FAST_IDX   = 2,
   parameter logic [7:0]  CTRL_RST   = 8'hB0,
   parameter logic [7:0]  TEST_RST   = 8'h0A,
   parameter int unsigned ADDR_W     = $clog2(2 + 2 * N_TMR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              base_tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              rom_enable
);
   localparam int unsigned A_TEST = 0;
   localparam int unsigned A_CTRL = 1;
   localparam int unsigned A_TGT0 = 2;
   localparam int unsigned A_CNT0 = A_TGT0 + N_TMR;
   localparam int unsigned IDX_W  = (N_TMR > 1) ? $clog2(N_TMR) : 1;

   generate
      if (N_TMR < 1 || N_TMR > 7) begin : g_bad_n
         $error("atu_timer_unit: N_TMR must be 1..7");
      end
      if (TGT_W < 1 || TGT_W > ATU_BUS_W || CNT_W < 1 || CNT_W > ATU_BUS_W) begin : g_bad_w
         $error("atu_timer_unit: widths must fit the byte bus");
      end
      if (FAST_IDX >= N_TMR) begin : g_bad_fast
         $error("atu_timer_unit: FAST_IDX out of range");
      end
      if ((2 + 2 * N_TMR) > (1 << ADDR_W)) begin : g_bad_addr
         $error("atu_timer_unit: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [7:0]                         ctrl_q;
   logic [7:0]                         test_q;
   logic [N_TMR-1:0][TGT_W-1:0]        tgt_q;
   logic [N_TMR-1:0][CNT_W-1:0]        cnt_q;
   logic [N_TMR-1:0]                   chan_tick;
   logic [N_TMR-1:0]                   start;
   logic [N_TMR-1:0]                   rd_clr;
   logic                               slow_tick;
   atu_sel_e                           sel;
   logic [IDX_W-1:0]                   idx;

   // address decode
   always_comb begin
      sel = SEL_NONE;
      idx = '0;
      if (int'(bus_addr) == A_TEST)
         sel = SEL_TEST;
      else if (int'(bus_addr) == A_CTRL)
         sel = SEL_CTRL;
      else if (int'(bus_addr) >= A_TGT0 && int'(bus_addr) < A_CNT0) begin
         sel = SEL_TGT;
         idx = IDX_W'(int'(bus_addr) - A_TGT0);
      end else if (int'(bus_addr) >= A_CNT0 && int'(bus_addr) < A_CNT0 + N_TMR) begin
         sel = SEL_CNT;
         idx = IDX_W'(int'(bus_addr) - A_CNT0);
      end
   end

   // writable registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         test_q <= TEST_RST;
         tgt_q  <= '0;
      end else if (soft_rst) begin
         ctrl_q <= CTRL_RST;
         test_q <= TEST_RST;
      end else if (bus_wr) begin
         case (sel)
            SEL_TEST: test_q     <= bus_wdata;
            SEL_CTRL: ctrl_q     <= bus_wdata;
            SEL_TGT:  tgt_q[idx] <= bus_wdata[TGT_W-1:0];
            default: ;
         endcase
      end
   end

   atu_prescale #(.RATIO(SLOW_RATIO)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_rst),
      .base_tick (base_tick),
      .slow_tick (slow_tick)
   );

   generate
      for (genvar i = 0; i < N_TMR; i++) begin : g_chan
         if (i == FAST_IDX) begin : g_fast
            assign chan_tick[i] = base_tick;
         end else begin : g_slow
            assign chan_tick[i] = slow_tick;
         end

         assign start[i]  = bus_wr && !soft_rst && (sel == SEL_CTRL)
                            && bus_wdata[i] && !ctrl_q[i];
         assign rd_clr[i] = bus_rd && (sel == SEL_CNT) && (int'(idx) == i);

         atu_channel #(.TGT_W(TGT_W), .CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_rst),
            .tick     (chan_tick[i]),
            .enable   (ctrl_q[i]),
            .start    (start[i]),
            .target   (tgt_q[i]),
            .rd_clr   (rd_clr[i]),
            .count    (cnt_q[i])
         );
      end
   endgenerate

   // only the output counters return data
   always_comb begin
      bus_rdata = '0;
      if (bus_rd && sel == SEL_CNT)
         bus_rdata = 8'(cnt_q[idx]);
   end

   assign rom_enable = ctrl_q[7];
endmodule

// File: rtl/atu_timer_unit_chk.sv
module atu_timer_unit_chk #(
   parameter int unsigned N_TMR    = 3,
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned ADDR_W   = 3,
   parameter logic [7:0]  CTRL_RST = 8'hB0,
   parameter logic [7:0]  TEST_RST = 8'h0A
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      soft_rst,
   input logic                      bus_wr,
   input logic                      bus_rd,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [7:0]                bus_wdata,
   input logic [7:0]                bus_rdata,
   input logic                      rom_enable,
   input logic [7:0]                ctrl_q,
   input logic [7:0]                test_q,
   input logic [N_TMR-1:0][CNT_W-1:0] cnt_q
);
   localparam int unsigned A_CTRL = 1;
   localparam int unsigned A_CNT0 = 2 + N_TMR;

   AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && int'(bus_addr) < A_CNT0) |-> (bus_rdata == 8'h00)); // R3

   AST_SOFT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl_q == CTRL_RST && test_q == TEST_RST && cnt_q == '0)); // R2

   AST_ROM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !soft_rst && int'(bus_addr) == A_CTRL)
      |=> (rom_enable == $past(bus_wdata[7]))); // R10

   generate
      for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
         AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && int'(bus_addr) == A_CTRL && bus_wdata[g] && !ctrl_q[g])
            |=> (cnt_q[g] == '0)); // R9

         AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_q[g] && !soft_rst && !bus_wr && !bus_rd)
            |=> $stable(cnt_q[g])); // R4

         AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && int'(bus_addr) == A_CNT0 + g)
            |=> (cnt_q[g] <= CNT_W'(1))); // R8

         AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!soft_rst && !bus_wr && !bus_rd)
            |=> (cnt_q[g] == $past(cnt_q[g]) ||
                 cnt_q[g] == CNT_W'($past(cnt_q[g]) + 1'b1))); // R7
      end
   endgenerate
endmodule

bind atu_timer_unit atu_timer_unit_chk #(
   .N_TMR    (N_TMR),
   .CNT_W    (CNT_W),
   .ADDR_W   (ADDR_W),
   .CTRL_RST (CTRL_RST),
   .TEST_RST (TEST_RST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst   (soft_rst),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .rom_enable (rom_enable),
   .ctrl_q     (ctrl_q),
   .test_q     (test_q),
   .cnt_q      (cnt_q)
);

// File: tb/atu_timer_unit_test.sv
module atu_timer_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       base_tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rom_enable;

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   atu_timer_unit uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .base_tick  (base_tick),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .rom_enable (rom_enable)
   );

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // driver: queue the expected read value, then issue the read
   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      base_tick = 1'b1;
      repeat (n) @(negedge clk);
      base_tick = 1'b0;
   endtask

   task automatic chk_rom(input logic e, input string tag);
      @(negedge clk);
      #5;
      checks++;
      if (rom_enable !== e) begin
         fails++;
         $display("FAIL %s rom_enable actual=%0b expected=%0b", tag, rom_enable, e);
      end
   endtask

   // monitor: compare each read against the queued expectation
   always @(negedge clk) begin
      #5;
      if (bus_rd) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, bus_addr, bus_rdata, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // hard reset state
      chk_rom(1'b1, "R1");
      rd(3'd5, 8'h0F, "R1");
      rd(3'd6, 8'h0F, "R1");
      rd(3'd7, 8'h0F, "R1");
      rd(3'd5, 8'h00, "R8");
      rd(3'd1, 8'h00, "R3");
      rd(3'd2, 8'h00, "R1");

      // fast and slow rates
      wr(3'd2, 8'd3);
      wr(3'd4, 8'd2);
      wr(3'd1, 8'h05);
      chk_rom(1'b0, "R10");
      ticks(24);
      rd(3'd7, 8'd12, "R6");
      rd(3'd5, 8'd1, "R6");
      rd(3'd6, 8'd0, "R4");
      rd(3'd7, 8'd0, "R8");

      // rewriting an enabled bit does not clear
      ticks(6);
      wr(3'd1, 8'h05);
      ticks(2);
      rd(3'd7, 8'd4, "R9");

      // rising enable clears divider and counter
      ticks(3);
      wr(3'd1, 8'h01);
      wr(3'd1, 8'h05);
      ticks(1);
      rd(3'd7, 8'd0, "R9");
      ticks(1);
      rd(3'd7, 8'd1, "R9");

      // target 0 is a period of 256
      wr(3'd1, 8'h00);
      wr(3'd4, 8'd0);
      wr(3'd1, 8'h04);
      ticks(255);
      rd(3'd7, 8'd0, "R5");
      ticks(1);
      rd(3'd7, 8'd1, "R5");

      // 4-bit wrap
      wr(3'd4, 8'd1);
      wr(3'd1, 8'h00);
      wr(3'd1, 8'h04);
      ticks(17);
      rd(3'd7, 8'd1, "R7");
      ticks(15);
      rd(3'd7, 8'd15, "R7");

      // write-only registers read zero
      wr(3'd0, 8'h55);
      wr(3'd3, 8'h77);
      rd(3'd0, 8'h00, "R3");
      rd(3'd3, 8'h00, "R3");
      rd(3'd4, 8'h00, "R3");

      // soft reset
      ticks(5);
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      chk_rom(1'b1, "R2");
      rd(3'd7, 8'd0, "R2");
      rd(3'd5, 8'd0, "R2");
      ticks(8);
      rd(3'd7, 8'd0, "R4");
      wr(3'd1, 8'h05);
      ticks(16);
      rd(3'd7, 8'd0, "R2");
      rd(3'd5, 8'd0, "R2");
      ticks(8);
      rd(3'd7, 8'd8, "R2");
      rd(3'd5, 8'd1, "R2");

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule